// File: doc/BRIEF.md
# Serially configured look-up-table logic cell

This block is one reconfigurable logic cell. A 16-entry, one-bit-wide table turns four logic inputs into a single result, so any Boolean function of four variables can be realised by choosing the table contents. That result either goes straight to the cell output or passes through a flip-flop first, which gives a registered output.

The table bits and two option bits sit in one serial shift chain. A host shifts a configuration stream in through a data input while a shift-enable input is high. The bits pushed out at the far end appear on a chain output, so many cells can be wired head-to-tail and loaded from one stream. One option bit picks a combinational or a registered output. The other decides whether the synchronous reset input may clear the output flip-flop.

Top module: `lut_cell`

## Requirements
- R1: The table holds 16 locations. The inputs `lut_in[3:0]`, read as an unsigned binary number with `lut_in[3]` as the most significant bit, select location i. The table result is the bit stored at location i, so location 0 holds f(0000) and location 15 holds f(1111).
- R2: When the output-mode bit is 0, `cell_out` equals the table result for the current inputs, with no clock edge in between.
- R3: When the output-mode bit is 1, `cell_out` changes only on a rising clock edge. Between edges it shows the table result sampled at the previous edge.
- R4: The chain is 18 bits long. It moves one position per rising edge while `cfg_shift` is 1. The stream order is table location 0 first, through location 15, then the output-mode bit, then the reset-enable bit. After 18 shifts the cell holds the complete new configuration.
- R5: Before the k-th shift edge of a load (counting from 0), `cfg_dout` shows bit k of the configuration being replaced, in the stream order of R4. This lets a downstream cell receive it.
- R6: When `cfg_shift` is 0 the chain keeps its contents. Asserting `rst` never changes them.
- R7: While `cfg_shift` is 1 the output flip-flop keeps its value. The new configuration first reaches the flip-flop on the first rising edge after `cfg_shift` returns to 0.
- R8: When `rst` is 1 at a rising edge, `cfg_shift` is 0 and the reset-enable bit is 1, the output flip-flop becomes 0 at that edge and not before.
- R9: When the reset-enable bit is 0, `rst` has no effect, and the output flip-flop captures the table result as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the chain and the output flip-flop |
| rst | input | 1 | Synchronous reset for the output flip-flop, active high, gated by the reset-enable bit |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, for cascading |
| lut_in | input | 4 | Logic inputs forming the table index |
| cell_out | output | 1 | Cell result, combinational or registered |

## Verification
In combinational mode a new input pattern is due at `cell_out` in the same cycle. The bench drives the pattern on a falling edge and samples 1 ns later. In registered mode the result is due one rising edge after the inputs settle. The bench therefore checks twice per pattern: before the edge, where the old value must still show, and 1 ns after the edge, where the new one must show. A reset clears the output on that same edge. A fresh configuration reaches the flip-flop on the first edge after shifting stops, so the bench checks the held value right after the load and the new value after the next edge. The bits leaving the chain are checked before every shift edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    // Output-mode option bit
    typedef enum logic {
        OMODE_COMB = 1'b0,
        OMODE_REG  = 1'b1
    } omode_e;

    // Output flip-flop state
    typedef struct packed {
        logic val;
    } ostage_t;

endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
    parameter int unsigned LEN = 18
) (
    input  logic           clk,
    input  logic           shift_en,
    input  logic           ser_in,
    output logic [LEN-1:0] bits_q,
    output logic           ser_out
);
    logic [LEN-1:0] bits_d;

    // New bits enter at the top; the bit at index 0 leaves first
    always_comb begin
        bits_d = bits_q;
        if (shift_en) begin
            bits_d = {ser_in, bits_q[LEN-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    assign ser_out = bits_q[0];
endmodule

// File: rtl/lut_table_mux.sv
module lut_table_mux #(
    parameter int unsigned K = 4,
    localparam int unsigned N = 1 << K
) (
    input  logic [N-1:0] table_bits,
    input  logic [K-1:0] index,
    output logic         result
);
    // Binary mux tree; level l keeps N >> l nodes
    logic [2*N-2:0] node;

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[i] = table_bits[i];
    end

    for (genvar l = 1; l <= K; l++) begin : g_lvl
        localparam int unsigned IN_BASE  = 2*N - (2*N >> (l-1));
        localparam int unsigned OUT_BASE = 2*N - (2*N >> l);
        for (genvar j = 0; j < (N >> l); j++) begin : g_node
            assign node[OUT_BASE + j] = index[l-1] ? node[IN_BASE + 2*j + 1]
                                                   : node[IN_BASE + 2*j];
        end
    end

    assign result = node[2*N-2];
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage
    import lut_cell_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  logic   rst_allow,
    input  omode_e mode,
    input  logic   d,
    output logic   ff_q,
    output logic   y
);
    ostage_t st_d, st_q;

    // Priority: hold while configuring, then gated reset, then capture
    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (rst && rst_allow) begin
                st_d.val = 1'b0;
            end else begin
                st_d.val = d;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ff_q = st_q.val;
    assign y    = (mode == OMODE_REG) ? st_q.val : d;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_shift,
    input  logic         cfg_din,
    output logic         cfg_dout,
    input  logic [K-1:0] lut_in,
    output logic         cell_out
);
    localparam int unsigned N         = 1 << K;
    localparam int unsigned MODE_BIT  = N;
    localparam int unsigned RSTEN_BIT = N + 1;
    localparam int unsigned CHAIN_LEN = N + 2;

    logic [CHAIN_LEN-1:0] chain_q;
    logic                 lut_val;
    logic                 out_q;

    lut_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk      (clk),
        .shift_en (cfg_shift),
        .ser_in   (cfg_din),
        .bits_q   (chain_q),
        .ser_out  (cfg_dout)
    );

    lut_table_mux #(.K(K)) u_mux (
        .table_bits (chain_q[N-1:0]),
        .index      (lut_in),
        .result     (lut_val)
    );

    lut_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .hold      (cfg_shift),
        .rst_allow (chain_q[RSTEN_BIT]),
        .mode      (omode_e'(chain_q[MODE_BIT])),
        .d         (lut_val),
        .ff_q      (out_q),
        .y         (cell_out)
    );
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
    parameter int unsigned LEN = 18
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_shift,
    input logic           cfg_din,
    input logic [LEN-1:0] chain_q,
    input logic           lut_val,
    input logic           out_q,
    input logic           cell_out
);
    localparam int unsigned MODE_BIT  = LEN - 2;
    localparam int unsigned RSTEN_BIT = LEN - 1;

    // R4: the shifted-in bit lands at the top of the chain
    a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |=> chain_q[LEN-1] == $past(cfg_din));

    // R6: the chain is frozen without shift enable
    a_r6_chain_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_shift |=> $stable(chain_q));

    // R7: the output flip-flop is frozen during a load
    a_r7_ff_hold: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |=> $stable(out_q));

    // R8: a reset cycle with reset enabled leaves the flip-flop at 0
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && $past(chain_q[RSTEN_BIT]) && !$past(cfg_shift)) |-> out_q == 1'b0);

    // R3: registered output equals the table result of the previous cycle
    a_r3_reg_follow: assert property (@(posedge clk) disable iff (rst)
        (chain_q[MODE_BIT] && !cfg_shift && !$past(cfg_shift) && !$past(rst))
            |-> cell_out == $past(lut_val));
endmodule

bind lut_cell lut_cell_chk #(.LEN(CHAIN_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_shift (cfg_shift),
    .cfg_din   (cfg_din),
    .chain_q   (chain_q),
    .lut_val   (lut_val),
    .out_q     (out_q),
    .cell_out  (cell_out)
);

// File: tb/lut_cell_test.sv
module lut_cell_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_shift = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;
    logic [3:0] lut_in = 4'd0;
    logic       cell_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [17:0] cur_cfg;
    logic        prev;

    always #4 clk = ~clk;  // 125 MHz

    lut_cell uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_shift (cfg_shift),
        .cfg_din   (cfg_din),
        .cfg_dout  (cfg_dout),
        .lut_in    (lut_in),
        .cell_out  (cell_out)
    );

    function automatic logic ref_lut(input logic [15:0] t, input logic [3:0] idx);
        return t[idx];
    endfunction

    function automatic logic [17:0] pack_cfg(input logic [15:0] t, input logic mode, input logic ren);
        return {ren, mode, t};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // R4 load; R5 readback of the displaced configuration
    task automatic load(input logic [17:0] cfg, input bit chk_old);
        for (int k = 0; k < 18; k++) begin
            @(negedge clk);
            cfg_din   = cfg[k];
            cfg_shift = 1'b1;
            #1;
            if (chk_old) check("R5", cfg_dout, cur_cfg[k]);
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cur_cfg   = cfg;
    endtask

    // R1/R2: every input pattern, combinational mode
    task automatic run_comb(input logic [15:0] t);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            lut_in = 4'(i);
            #1 check("R1/R2", cell_out, ref_lut(t, 4'(i)));
        end
    endtask

    task automatic reg_step(input logic [15:0] t, input logic [3:0] v);
        @(negedge clk);
        lut_in = v;
        #1 check("R3 pre-edge", cell_out, prev);
        @(posedge clk);
        #1 check("R1/R3 post-edge", cell_out, ref_lut(t, v));
        prev = ref_lut(t, v);
    endtask

    // R3: all patterns plus random ones, registered mode
    task automatic run_reg(input logic [15:0] t, input int extra);
        @(negedge clk);
        lut_in = 4'd0;
        @(posedge clk);
        #1 prev = ref_lut(t, 4'd0);
        for (int i = 0; i < 16; i++) reg_step(t, 4'(15 - i));
        for (int i = 0; i < extra; i++) reg_step(t, 4'($urandom_range(15)));
    endtask

    initial begin
        logic [15:0] t;
        logic [3:0]  v;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Two-input AND of lut_in[1:0]: locations 3,7,11,15
        load(pack_cfg(16'h8888, 1'b1, 1'b1), 1'b0);
        @(negedge clk);
        lut_in = 4'd3;
        rst = 1'b1;
        @(posedge clk);
        #1 check("R8 reset state", cell_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        run_reg(16'h8888, 4);
        load(pack_cfg(16'h8888, 1'b0, 1'b1), 1'b1);
        run_comb(16'h8888);

        // Four-input XOR
        load(pack_cfg(16'h6996, 1'b0, 1'b1), 1'b1);
        run_comb(16'h6996);
        load(pack_cfg(16'h6996, 1'b1, 1'b1), 1'b1);
        run_reg(16'h6996, 4);

        // R8: synchronous clear, not before the edge
        @(negedge clk);
        lut_in = 4'd1;
        @(posedge clk);
        #1 check("R3", cell_out, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        #1 check("R8 before edge", cell_out, 1'b1);
        @(posedge clk);
        #1 check("R8 cleared", cell_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        // R6: reset left the chain intact; the next load reads it back via R5
        load(pack_cfg(16'h6996, 1'b1, 1'b0), 1'b1);

        // R9: reset disabled, flip-flop keeps capturing
        @(negedge clk);
        lut_in = 4'd0;
        @(posedge clk);
        #1 check("R3", cell_out, 1'b0);
        @(negedge clk);
        lut_in = 4'd7;
        rst = 1'b1;
        @(posedge clk);
        #1 check("R9 reset ignored", cell_out, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // Random functions in both modes
        for (int r = 0; r < 6; r++) begin
            t = 16'($urandom);
            load(pack_cfg(t, 1'b0, 1'b1), 1'b1);
            run_comb(t);
            load(pack_cfg(t, 1'b1, 1'b1), 1'b1);
            run_reg(t, 12);

            // R7: hold during a load, new table on the first edge after it
            v = lut_in;
            t = 16'($urandom);
            t[v] = ~prev;
            load(pack_cfg(t, 1'b1, 1'b1), 1'b1);
            #1 check("R7 held after load", cell_out, prev);
            @(posedge clk);
            #1 check("R7 new config applied", cell_out, ref_lut(t, v));
            prev = ref_lut(t, v);
        end

        // R6: chain unchanged over idle cycles with reset pulses
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        load(pack_cfg(16'h0001, 1'b0, 1'b0), 1'b1);
        @(negedge clk);
        lut_in = 4'd0;
        #1 check("R6/R2", cell_out, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule